// File: doc/BRIEF.md
# Per-Set Age-Counter Recency Tracker

This block keeps the use order of the ways in each set of a set-associative cache and names the way to evict. Every way of every set holds a small age counter of log2(WAYS) bits. Within a set the counters are always a permutation of 0 to WAYS-1. Age 0 marks the way that has gone unused the longest. Age WAYS-1 marks the way touched most recently.

The cache controller pulses `acc_valid` with a set and way index whenever a way is used. This covers hits as well as fills after a miss. A separate `look_set` index selects the set whose ages and victim are shown at the outputs. When a new line must be placed in that set, the controller reads the victim output. Tags, hit detection and data storage live outside this block.

Top module: `lru_tracker`

## Requirements
- R1: While `rst_n` is sampled low on a clock edge, every set is loaded with age w for way w. After reset the victim of every set is way 0.
- R2: One cycle after an access to set s and way w, the age of way w in set s equals WAYS-1.
- R3: On an access, every other way in the same set whose age was above the touched way's old age drops by one. Every way whose age was below it keeps its age.
- R4: An access to the way whose age is already WAYS-1 leaves all ages of that set unchanged.
- R5: `victim_way` is the index of the way in the looked-at set whose age is 0. It follows `look_set` and the stored ages combinationally, with no clock edge needed.
- R6: After any sequence of accesses, the ages of every set form a permutation of 0 to WAYS-1.
- R7: An access to one set leaves the ages of all other sets unchanged.
- R8: A clock edge with `acc_valid` low changes no age.
- R9: `ages` carries the age of way w of the looked-at set in bits [w*log2(WAYS) +: log2(WAYS)].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| acc_valid | input | 1 | An access (hit or fill) occurs this cycle |
| acc_set | input | log2(SETS) | Set that was accessed |
| acc_way | input | log2(WAYS) | Way that was accessed |
| look_set | input | log2(SETS) | Set shown at the outputs |
| victim_way | output | log2(WAYS) | Least recently used way of the looked-at set |
| ages | output | WAYS*log2(WAYS) | Age counters of the looked-at set, way 0 in the low bits |

## Verification
An access is registered on the edge where `acc_valid` is sampled high. Its effect on the ages and the victim is therefore due one cycle later, and the bench compares both at the following falling edge against a behavioural array model that it updates at that same edge. A change of `look_set` alone must show in `ages` and `victim_way` within the same cycle. The bench checks this a moment after driving the new index, before any clock edge. The checker compares each post-access state with the state one cycle earlier. Every property of that kind excuses cycles in which `look_set` moved, because then the outputs show a different set.

// File: rtl/lru_pkg.sv
// Package: shared types and the per-counter update rule for the
// age-counter recency tracker. Assumes ages are unsigned and that the
// touched way's old age is known when the rule is applied.
package lru_pkg;

    // What a single age counter does on a given access.
    typedef enum logic [1:0] {
        AGE_HOLD = 2'd0,   // no change
        AGE_TOP  = 2'd1,   // becomes most recent
        AGE_DROP = 2'd2    // moves one step toward eviction
    } age_op_e;

    // Decide the operation for one counter: touched ways go to the top,
    // counters above the touched way's old age step down, others hold.
    function automatic age_op_e pick_op(input logic hit_me,
                                        input logic [7:0] my_age,
                                        input logic [7:0] ref_age);
        if (hit_me)
            return AGE_TOP;
        else if (my_age > ref_age)
            return AGE_DROP;
        else
            return AGE_HOLD;
    endfunction

endpackage

// File: rtl/lru_age_cell.sv
// Module: one age counter of one way. Loads INIT on reset, applies the
// shared update rule when its set is accessed. Assumes ref_age is the
// touched way's age before this access.
module lru_age_cell
    import lru_pkg::*;
#(
    parameter int W    = 2,
    parameter int TOP  = 3,
    parameter logic [W-1:0] INIT = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd_en,
    input  logic         hit_me,
    input  logic [W-1:0] ref_age,
    output logic [W-1:0] age
);

    age_op_e op;

    // Classify this counter's reaction to the current access.
    always_comb begin
        op = pick_op(hit_me, 8'(age), 8'(ref_age));
    end

    // Hold the age; reset to the way's own index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            age <= INIT;
        end else if (upd_en) begin
            case (op)
                AGE_TOP:  age <= W'(TOP);
                AGE_DROP: age <= age - 1'b1;
                default:  age <= age;
            endcase
        end
    end

endmodule

// File: rtl/lru_set_bank.sv
// Module: the age counters of one set. Looks up the touched way's old
// age and drives every cell with it. Assumes acc_way < WAYS.
module lru_set_bank #(
    parameter int WAYS = 4,
    parameter int W    = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd_en,
    input  logic [W-1:0]      acc_way,
    output logic [WAYS*W-1:0] ages_flat
);

    logic [W-1:0] age_q [WAYS];
    logic [W-1:0] old_age;

    // Pick the touched way's current age.
    always_comb begin
        old_age = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (acc_way == W'(w))
                old_age = age_q[w];
        end
    end

    for (genvar g = 0; g < WAYS; g++) begin : g_way
        lru_age_cell #(
            .W    (W),
            .TOP  (WAYS - 1),
            .INIT (W'(g))
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .upd_en  (upd_en),
            .hit_me  (acc_way == W'(g)),
            .ref_age (old_age),
            .age     (age_q[g])
        );
        assign ages_flat[g*W +: W] = age_q[g];
    end

endmodule

// File: rtl/lru_victim_pick.sv
// Module: finds the way whose age is zero. Assumes the ages form a
// permutation, so exactly one way matches.
module lru_victim_pick #(
    parameter int WAYS = 4,
    parameter int W    = $clog2(WAYS)
) (
    input  logic [WAYS*W-1:0] ages_flat,
    output logic [W-1:0]      victim
);

    logic [WAYS-1:0] is_zero;

    for (genvar g = 0; g < WAYS; g++) begin : g_cmp
        assign is_zero[g] = (ages_flat[g*W +: W] == '0);
    end

    // Encode the single zero-age way into an index (OR of matches).
    always_comb begin
        victim = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (is_zero[w])
                victim = victim | W'(w);
        end
    end

endmodule

// File: rtl/lru_tracker.sv
// Module (top): recency tracker for SETS sets of WAYS ways. Accesses
// update the addressed set one cycle later; outputs show look_set
// combinationally. Assumes WAYS is a power of two, at least 2.
module lru_tracker #(
    parameter int WAYS = 4,
    parameter int SETS = 4,
    localparam int W   = $clog2(WAYS),
    localparam int SW  = (SETS > 1) ? $clog2(SETS) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_valid,
    input  logic [SW-1:0]     acc_set,
    input  logic [W-1:0]      acc_way,
    input  logic [SW-1:0]     look_set,
    output logic [W-1:0]      victim_way,
    output logic [WAYS*W-1:0] ages
);

    logic [WAYS*W-1:0] bank_ages [SETS];

    for (genvar s = 0; s < SETS; s++) begin : g_set
        lru_set_bank #(
            .WAYS (WAYS),
            .W    (W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .upd_en    (acc_valid && (acc_set == SW'(s))),
            .acc_way   (acc_way),
            .ages_flat (bank_ages[s])
        );
    end

    // Route the looked-at set to the outputs.
    always_comb begin
        ages = '0;
        for (int s = 0; s < SETS; s++) begin
            if (look_set == SW'(s))
                ages = bank_ages[s];
        end
    end

    lru_victim_pick #(
        .WAYS (WAYS),
        .W    (W)
    ) u_pick (
        .ages_flat (ages),
        .victim    (victim_way)
    );

endmodule

// File: rtl/lru_tracker_chk.sv
// Module: property checker for lru_tracker, attached by bind. Uses only
// the top-level ports.
module lru_tracker_chk #(
    parameter int WAYS = 4,
    parameter int SETS = 4,
    localparam int W   = $clog2(WAYS),
    localparam int SW  = (SETS > 1) ? $clog2(SETS) : 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              acc_valid,
    input logic [SW-1:0]     acc_set,
    input logic [W-1:0]      acc_way,
    input logic [SW-1:0]     look_set,
    input logic [W-1:0]      victim_way,
    input logic [WAYS*W-1:0] ages
);

    logic [W-1:0]      age_acc, age_vic, age_last, last_way;
    logic [(1<<W)-1:0] seen;

    // Remember last cycle's accessed way.
    always_ff @(posedge clk) begin
        if (!rst_n) last_way <= '0;
        else        last_way <= acc_way;
    end

    // Gather per-way views of the output ages.
    always_comb begin
        age_acc  = '0;
        age_vic  = '0;
        age_last = '0;
        seen     = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (acc_way == W'(w))    age_acc  = ages[w*W +: W];
            if (victim_way == W'(w)) age_vic  = ages[w*W +: W];
            if (last_way == W'(w))   age_last = ages[w*W +: W];
            seen[ages[w*W +: W]] = 1'b1;
        end
    end

    assert_touch_top_R2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_set == look_set |=>
            (look_set != $past(look_set)) || (age_last == W'(WAYS - 1)));

    assert_mru_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_set == look_set && age_acc == W'(WAYS - 1) |=>
            (look_set != $past(look_set)) || (ages == $past(ages)));

    assert_victim_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
        age_vic == '0);

    assert_permutation_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seen[WAYS-1:0]) == WAYS);

    assert_other_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        acc_valid && acc_set != look_set |=>
            (look_set != $past(look_set)) || (ages == $past(ages)));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_valid |=> (look_set != $past(look_set)) || (ages == $past(ages)));

endmodule

bind lru_tracker lru_tracker_chk #(.WAYS(WAYS), .SETS(SETS)) u_chk (.*);

// File: tb/sim_lru_tracker.sv
`timescale 1ns/1ps
module sim_lru_tracker;
    localparam int WAYS = 4;
    localparam int SETS = 4;
    localparam int W    = 2;
    localparam int SW   = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic acc_valid = 1'b0;
    logic [SW-1:0] acc_set = '0;
    logic [W-1:0]  acc_way = '0;
    logic [SW-1:0] look_set = '0;
    logic [W-1:0]  victim_way;
    logic [WAYS*W-1:0] ages;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    bit done = 0;
    int mdl [SETS][WAYS];

    always #2 clk = ~clk;

    lru_tracker #(.WAYS(WAYS), .SETS(SETS)) u0 (.*);

    task automatic chk(input int got, input int exp, input string req);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s: got=%0d expected=%0d", req, got, exp);
        end
    endtask

    // Compare all outputs for set ls against the model.
    task automatic compare(input int ls, input string tag);
        int vexp = -1;
        bit [WAYS-1:0] seen = '0;
        for (int w = 0; w < WAYS; w++) begin
            int g = int'(ages[w*W +: W]);
            chk(g, mdl[ls][w], tag);
            if (mdl[ls][w] == 0) vexp = w;
            seen[g] = 1'b1;
        end
        chk(int'(victim_way), vexp, "R5");
        chk($countones(seen), WAYS, "R6");
    endtask

    // One cycle starting at a falling edge: drive, clock, model, compare.
    task automatic step(input bit v, input int s, input int w, input int ls);
        string tag;
        int old;
        acc_valid = v; acc_set = SW'(s); acc_way = W'(w); look_set = SW'(ls);
        @(posedge clk);
        old = mdl[s][w];
        if (!v) tag = "R8";
        else if (s != ls) tag = "R7";
        else if (old == WAYS - 1) tag = "R4";
        else tag = "R2/R3";
        if (v) begin
            for (int k = 0; k < WAYS; k++) begin
                if (k == w) mdl[s][k] = WAYS - 1;
                else if (mdl[s][k] > old) mdl[s][k]--;
            end
        end
        @(negedge clk);
        compare(ls, tag);
    endtask

    // Change only look_set and check outputs before any clock edge (R5, R9).
    task automatic peek(input int ls, input string tag);
        acc_valid = 1'b0;
        look_set = SW'(ls);
        #0.5;
        compare(ls, tag);
    endtask

    initial begin
        for (int s = 0; s < SETS; s++)
            for (int w = 0; w < WAYS; w++) mdl[s][w] = w;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 and R9: reset pattern on every set, bit layout per way.
        for (int s = 0; s < SETS; s++) peek(s, "R1/R9");
        // R4: way 3 already most recent.
        step(1, 0, 3, 0);
        // R2/R3: touch oldest way, then again, then a middle way.
        step(1, 0, 0, 0);
        step(1, 0, 0, 0);
        step(1, 0, 2, 0);
        step(1, 0, 1, 0);
        // R8: idle cycles.
        step(0, 0, 1, 0);
        step(0, 2, 3, 0);
        // R7: access set 1 while looking at set 0, then view set 1.
        step(1, 1, 0, 0);
        step(1, 1, 2, 0);
        peek(1, "R7");
        peek(0, "R5");
        // Mixed random traffic.
        for (int i = 0; i < 3000; i++) begin
            int s = $urandom_range(SETS - 1);
            int ls = ($urandom_range(3) == 0) ? $urandom_range(SETS - 1) : s;
            step($urandom_range(7) != 0, s, $urandom_range(WAYS - 1), ls);
        end
        // Hammer the same way repeatedly (R4).
        for (int i = 0; i < 4; i++) step(1, 3, 1, 3);
        for (int s = 0; s < SETS; s++) peek(s, "R6");
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: end a hung run as a failure.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            bad++;
            total++;
            $display("FAIL watchdog: got=%0d expected=%0d", cycles, 100000);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule